// File: doc/BRIEF.md
# Parallel SAT Implication Engine

This block performs Boolean constraint propagation for a small formula in conjunctive normal form. A host holds the search. It loads one literal-select mask into each clause cell, writes a partial truth assignment, and pulses `start`. The engine sends every variable's state to every clause cell on a shared set of literal lines. The per-clause mask passes only the literals that clause uses. All clauses are evaluated together, once per clock cycle.

In each cycle, every clause cell counts its literals that are not yet false, and the count saturates at two. A clause with no such literal is falsified. A clause with exactly one such literal and no true literal forces that literal true. The forced values of all clauses are merged per variable and written back. Propagation then continues on the next cycle, until an evaluation forces nothing or a conflict appears. The host reads the implied assignment, `done` and `conflict`, and then decides its next step. The engine does no search, backtracking or clause learning.

Top module: `sat_bcp_engine`

## Requirements
- R1: After reset, every variable is unassigned, every clause mask is zero, and `busy`, `done` and `conflict` are low.
- R2: While the engine is not busy, a cycle with `cfg_shift` high shifts `cfg_bit` into bit 0 of the mask of the clause selected by `cfg_clause`. The older bits move up one place. Mask bit 2v selects the positive literal of variable v, and bit 2v+1 selects its negative literal. The masks of the other clauses are unchanged. `cfg_shift` has no effect while `busy` is high.
- R3: A clause with two or more non-false literals and no true literal forces nothing.
- R4: A clause with exactly one non-false literal and no true literal forces the variable of that literal to the value that makes the literal true. A variable that already holds a value is never changed by propagation.
- R5: One evaluation of all clauses happens per clock cycle. `busy` is high from the edge that samples `start` until propagation ends. If W evaluations add new values, `done` rises on the (W+1)-th clock edge after the start edge. `busy` and `done` are never high together, and `done` stays high until the next start.
- R6: A clause whose selected literals are all false raises `conflict` and `done`. A clause with no selected literals counts as falsified.
- R7: If, in one evaluation, one clause forces a variable to 1 and another clause forces it to 0, the engine raises `conflict` and `done`.
- R8: When an evaluation finds a conflict, none of its forced values is applied. The assignment then stays frozen until the host writes to it or pulses `start` again. A new start clears `conflict`.
- R9: While the engine is not busy, `asg_wr` stores `asg_val` into variable `asg_var`. The encoding is 00 unassigned, 01 false and 10 true, and a written 11 is stored as unassigned. `asg_wr` has no effect while `busy` is high. `assign_o[2v+1:2v]` shows the state of variable v.
- R10: A clause that has a true literal forces nothing, even when all its other literals are false.
- R11: For any formula and partial assignment, the final assignment and the conflict outcome equal those of repeated all-clause unit propagation run to a fixed point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift | input | 1 | Shift one mask bit into the selected clause |
| cfg_clause | input | CW | Clause selected for mask loading |
| cfg_bit | input | 1 | Serial mask bit |
| asg_wr | input | 1 | Write one variable of the partial assignment |
| asg_var | input | VW | Variable index for the write |
| asg_val | input | 2 | Value to write (00 free, 01 false, 10 true) |
| start | input | 1 | Begin propagation |
| assign_o | output | 2*NUM_VARS | Current assignment, two bits per variable |
| busy | output | 1 | Propagation in progress |
| done | output | 1 | Propagation finished (fixed point or conflict) |
| conflict | output | 1 | Propagation ended in a conflict |

## Verification
The bench builds the engine with 6 variables and 8 clauses. With a 12-bit mask per clause, a random formula often produces chains of forced values several steps long, as well as unit clauses that collide on the same variable. The small size keeps each mask load short, so a run can afford dozens of random formulas and assignments. It also keeps a bench-side fixed-point model cheap to evaluate, and that model predicts both the final values and the exact cycle on which `done` rises. Directed cases cover a two-step chain, an opposite-force contradiction, a falsified clause, satisfied and two-literal clauses, and writes attempted during a run.

// File: rtl/sat_pkg.sv
package sat_pkg;

    // Two-bit variable state carried on the broadcast lines
    localparam logic [1:0] VAL_FREE = 2'b00;
    localparam logic [1:0] VAL_ZERO = 2'b01;
    localparam logic [1:0] VAL_ONE  = 2'b10;

    // Saturating count of live (not false) literals in a clause
    typedef enum logic [1:0] {
        CNT_NONE = 2'd0,
        CNT_ONE  = 2'd1,
        CNT_MANY = 2'd2
    } live_cnt_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE,
        ST_CONFLICT
    } eng_state_t;

    typedef struct packed {
        logic satisfied;
        logic falsified;
        logic unit;
    } clause_flags_t;

    function automatic live_cnt_t cnt_bump(input live_cnt_t c, input logic hit);
        if (!hit)             return c;
        if (c == CNT_NONE)    return CNT_ONE;
        return CNT_MANY;
    endfunction

    function automatic logic [1:0] norm_val(input logic [1:0] v);
        return (v == 2'b11) ? VAL_FREE : v;
    endfunction

endpackage

// File: rtl/sat_one_active.sv
module sat_one_active
    import sat_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] lines,
    output live_cnt_t    cnt
);
    // Unary-to-count encoder that stops at two
    always_comb begin
        cnt = CNT_NONE;
        for (int i = 0; i < W; i++) begin
            cnt = cnt_bump(cnt, lines[i]);
        end
    end
endmodule

// File: rtl/sat_clause_cell.sv
module sat_clause_cell
    import sat_pkg::*;
#(
    parameter  int NUM_VARS = 32,
    localparam int MW       = 2 * NUM_VARS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_en,
    input  logic          shift_bit,
    input  logic          hold,
    input  logic [MW-1:0] lit_false,
    input  logic [MW-1:0] lit_true,
    output logic [MW-1:0] force_lits,
    output clause_flags_t flags
);
    logic [MW-1:0] mask_q;
    logic [MW-1:0] live;
    live_cnt_t     cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (shift_en && !hold) begin
            mask_q <= {mask_q[MW-2:0], shift_bit};
        end
    end

    assign live = mask_q & ~lit_false;

    sat_one_active #(.W(MW)) u_cnt (
        .lines (live),
        .cnt   (cnt)
    );

    always_comb begin
        flags.satisfied = |(mask_q & lit_true);
        flags.falsified = (cnt == CNT_NONE);
        flags.unit      = (cnt == CNT_ONE) && !flags.satisfied;
        force_lits      = flags.unit ? live : '0;
    end

    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (rst)
        ((cnt == CNT_NONE) == (live == '0)) &&
        ((cnt == CNT_ONE)  == ($countones(live) == 1)) &&
        ((cnt == CNT_MANY) == ($countones(live) >= 2))); // R3

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(mask_q)); // R2

    AST_UNIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(force_lits)); // R4
endmodule

// File: rtl/sat_var_slot.sv
module sat_var_slot
    import sat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_val,
    input  logic       apply,
    input  logic       force_one,
    input  logic       force_zero,
    output logic [1:0] val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            val <= VAL_FREE;
        end else if (wr_en) begin
            val <= norm_val(wr_val);
        end else if (apply && val == VAL_FREE) begin
            if (force_one) begin
                val <= VAL_ONE;
            end else if (force_zero) begin
                val <= VAL_ZERO;
            end
        end
    end

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        (val != VAL_FREE && !wr_en) |=> (val == $past(val))); // R4

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
        val != 2'b11); // R9
endmodule

// File: rtl/sat_bcp_engine.sv
module sat_bcp_engine
    import sat_pkg::*;
#(
    parameter  int NUM_VARS    = 32,
    parameter  int NUM_CLAUSES = 48,
    localparam int MW          = 2 * NUM_VARS,
    localparam int VW          = (NUM_VARS > 1) ? $clog2(NUM_VARS) : 1,
    localparam int CW          = (NUM_CLAUSES > 1) ? $clog2(NUM_CLAUSES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_shift,
    input  logic [CW-1:0] cfg_clause,
    input  logic          cfg_bit,
    input  logic          asg_wr,
    input  logic [VW-1:0] asg_var,
    input  logic [1:0]    asg_val,
    input  logic          start,
    output logic [MW-1:0] assign_o,
    output logic          busy,
    output logic          done,
    output logic          conflict
);
    eng_state_t          st_q;
    logic [MW-1:0]       lit_false;
    logic [MW-1:0]       lit_true;
    logic [MW-1:0]       frc   [NUM_CLAUSES];
    clause_flags_t       flags [NUM_CLAUSES];
    logic [NUM_VARS-1:0] f1, f0;
    logic                any_false, contra_any, any_force, conflict_now, apply;

    // Broadcast literal lines: even bit = positive literal, odd bit = negative
    for (genvar v = 0; v < NUM_VARS; v++) begin : g_var
        logic [1:0] val;

        sat_var_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (asg_wr && !busy && asg_var == VW'(v)),
            .wr_val     (asg_val),
            .apply      (apply),
            .force_one  (f1[v]),
            .force_zero (f0[v]),
            .val        (val)
        );

        assign assign_o[2*v +: 2]  = val;
        assign lit_false[2*v]      = (val == VAL_ZERO);
        assign lit_false[2*v + 1]  = (val == VAL_ONE);
        assign lit_true[2*v]       = (val == VAL_ONE);
        assign lit_true[2*v + 1]   = (val == VAL_ZERO);
    end

    for (genvar c = 0; c < NUM_CLAUSES; c++) begin : g_clause
        sat_clause_cell #(.NUM_VARS(NUM_VARS)) u_cell (
            .clk        (clk),
            .rst        (rst),
            .shift_en   (cfg_shift && cfg_clause == CW'(c)),
            .shift_bit  (cfg_bit),
            .hold       (busy),
            .lit_false  (lit_false),
            .lit_true   (lit_true),
            .force_lits (frc[c]),
            .flags      (flags[c])
        );
    end

    // Merge forced literals of all clauses per variable
    always_comb begin
        f1        = '0;
        f0        = '0;
        any_false = 1'b0;
        for (int c = 0; c < NUM_CLAUSES; c++) begin
            any_false |= flags[c].falsified;
            for (int v = 0; v < NUM_VARS; v++) begin
                f1[v] |= frc[c][2*v];
                f0[v] |= frc[c][2*v + 1];
            end
        end
        contra_any   = |(f1 & f0);
        any_force    = |(f1 | f0);
        conflict_now = any_false || contra_any;
        apply        = (st_q == ST_RUN) && !conflict_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_RUN: begin
                    if (conflict_now) begin
                        st_q <= ST_CONFLICT;
                    end else if (!any_force) begin
                        st_q <= ST_DONE;
                    end
                end
                default: begin
                    if (start) begin
                        st_q <= ST_RUN;
                    end
                end
            endcase
        end
    end

    assign busy     = (st_q == ST_RUN);
    assign done     = (st_q == ST_DONE) || (st_q == ST_CONFLICT);
    assign conflict = (st_q == ST_CONFLICT);

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)); // R5

    AST_CONFLICT_HAS_DONE: assert property (@(posedge clk) disable iff (rst)
        conflict |-> done); // R6

    AST_CONFLICT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (conflict && !start && !asg_wr) |=> $stable(assign_o)); // R8

    AST_CONTRA_STOPS: assert property (@(posedge clk) disable iff (rst)
        (busy && contra_any) |=> (conflict && $stable(assign_o))); // R7

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done); // R5
endmodule

// File: tb/sim_sat_bcp_engine.sv
module sim_sat_bcp_engine;
    localparam int NV = 6;
    localparam int NC = 8;
    localparam int MW = 2 * NV;
    localparam int VW = 3;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_shift;
    logic [CW-1:0] cfg_clause;
    logic          cfg_bit;
    logic          asg_wr;
    logic [VW-1:0] asg_var;
    logic [1:0]    asg_val;
    logic          start;
    logic [MW-1:0] assign_o;
    logic          busy, done, conflict;

    int n_total = 0;
    int n_fail  = 0;
    int cycles  = 0;

    logic [MW-1:0] m_mask [NC];
    logic [1:0]    m_val  [NV];

    always #5 clk = ~clk;

    sat_bcp_engine #(.NUM_VARS(NV), .NUM_CLAUSES(NC)) u0 (
        .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_clause(cfg_clause),
        .cfg_bit(cfg_bit), .asg_wr(asg_wr), .asg_var(asg_var), .asg_val(asg_val),
        .start(start), .assign_o(assign_o), .busy(busy), .done(done),
        .conflict(conflict)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: run did not end, actual %0d cycles expected < 150000", cycles);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    task automatic check(input string tag, input logic ok,
                         input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [MW-1:0] lit(input int v, input int neg);
        return MW'(1) << (2 * v + neg);
    endfunction

    function automatic logic [MW-1:0] pack_model();
        logic [MW-1:0] p;
        for (int v = 0; v < NV; v++) p[2*v +: 2] = m_val[v];
        return p;
    endfunction

    task automatic load_clause(input int c, input logic [MW-1:0] mk);
        for (int b = MW - 1; b >= 0; b--) begin
            cfg_shift  = 1'b1;
            cfg_clause = CW'(c);
            cfg_bit    = mk[b];
            @(negedge clk);
        end
        cfg_shift = 1'b0;
        m_mask[c] = mk;
    endtask

    task automatic set_var(input int v, input logic [1:0] x);
        asg_wr  = 1'b1;
        asg_var = VW'(v);
        asg_val = x;
        @(negedge clk);
        asg_wr  = 1'b0;
        m_val[v] = (x == 2'b11) ? 2'b00 : x;
    endtask

    task automatic set_all(input logic [1:0] x [NV]);
        for (int v = 0; v < NV; v++) set_var(v, x[v]);
    endtask

    // Fixed-point unit propagation over the model arrays
    task automatic model_run(output int waves, output logic confl);
        logic [NV-1:0] f1, f0;
        logic bad;
        waves = 0;
        confl = 1'b0;
        for (int it = 0; it < 64; it++) begin
            f1 = '0; f0 = '0; bad = 1'b0;
            for (int c = 0; c < NC; c++) begin
                int live; int last; logic sat;
                live = 0; last = 0; sat = 1'b0;
                for (int l = 0; l < MW; l++) begin
                    if (m_mask[c][l]) begin
                        logic isf, ist;
                        isf = (l % 2 == 0) ? (m_val[l/2] == 2'b01) : (m_val[l/2] == 2'b10);
                        ist = (l % 2 == 0) ? (m_val[l/2] == 2'b10) : (m_val[l/2] == 2'b01);
                        if (!isf) begin live++; last = l; end
                        if (ist) sat = 1'b1;
                    end
                end
                if (live == 0) bad = 1'b1;
                else if (live == 1 && !sat) begin
                    if (last % 2 == 0) f1[last/2] = 1'b1;
                    else f0[last/2] = 1'b1;
                end
            end
            if ((f1 & f0) != '0) bad = 1'b1;
            if (bad) begin confl = 1'b1; break; end
            if ((f1 | f0) == '0) break;
            for (int v = 0; v < NV; v++) begin
                if (m_val[v] == 2'b00 && f1[v]) m_val[v] = 2'b10;
                else if (m_val[v] == 2'b00 && f0[v]) m_val[v] = 2'b01;
            end
            waves++;
        end
    endtask

    // Start a run, optionally poking config and writes while busy, compare with model
    task automatic do_run(input string tag, input logic poke);
        int waves; int n;
        logic mc;
        logic [MW-1:0] expv;
        model_run(waves, mc);
        expv  = pack_model();
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check({tag, " R5 busy after start"}, busy === 1'b1 && done === 1'b0,
              {62'd0, busy, done}, 64'h2);
        if (poke) begin
            asg_wr = 1'b1; asg_var = '0; asg_val = 2'b10;
            cfg_shift = 1'b1; cfg_clause = '0; cfg_bit = 1'b1;
        end
        n = 0;
        while (done !== 1'b1 && n < 200) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            asg_wr = 1'b0;
            cfg_shift = 1'b0;
        end
        check({tag, " R5 cycles to done"}, n == waves + 1, 64'(n), 64'(waves + 1));
        check({tag, " R11 assignment"}, assign_o === expv, 64'(assign_o), 64'(expv));
        check({tag, " R11 conflict"}, conflict === mc, 64'(conflict), 64'(mc));
    endtask

    initial begin
        logic [1:0] a [NV];
        logic [MW-1:0] filler;
        rst = 1'b1; cfg_shift = 0; cfg_clause = 0; cfg_bit = 0;
        asg_wr = 0; asg_var = 0; asg_val = 0; start = 0;
        for (int c = 0; c < NC; c++) m_mask[c] = '0;
        for (int v = 0; v < NV; v++) m_val[v] = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        check("R1 reset outputs", assign_o === '0 && busy === 0 && done === 0 && conflict === 0,
              {48'd0, 1'b0, busy, done, conflict, assign_o}, 64'd0);
        // All masks zero: every clause is empty, hence falsified
        do_run("R1 R6 empty masks", 1'b0);
        check("R6 empty clause conflict", conflict === 1'b1, 64'(conflict), 64'd1);

        filler = lit(4, 0) | lit(5, 0);
        for (int c = 0; c < NC; c++) load_clause(c, filler);

        // Two-step chain: B=1 forces A=0, then C=0; third clause stays with two live literals
        load_clause(0, lit(0, 1) | lit(1, 1));
        load_clause(1, lit(0, 0) | lit(2, 1));
        load_clause(2, lit(2, 0) | lit(3, 0) | lit(4, 0));
        a = '{2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00};
        set_all(a);
        do_run("R4 R5 chain", 1'b0);
        check("R4 A forced false", assign_o[1:0] === 2'b01, 64'(assign_o[1:0]), 64'd1);
        check("R4 C forced false", assign_o[5:4] === 2'b01, 64'(assign_o[5:4]), 64'd1);
        check("R3 two live literals no force", assign_o[7:6] === 2'b00 && assign_o[9:8] === 2'b00,
              64'(assign_o[9:6]), 64'd0);
        repeat (3) @(negedge clk);
        check("R5 done holds", done === 1'b1 && busy === 1'b0, {62'd0, done, busy}, 64'h2);

        // Opposite forces on B from A=1 and C=1
        load_clause(0, lit(0, 1) | lit(1, 0));
        load_clause(1, lit(2, 1) | lit(1, 1));
        load_clause(2, filler);
        a = '{2'b10, 2'b00, 2'b10, 2'b00, 2'b00, 2'b00};
        set_all(a);
        do_run("R7 contradiction", 1'b0);
        check("R7 conflict raised", conflict === 1'b1 && done === 1'b1,
              {62'd0, conflict, done}, 64'h3);
        check("R8 no force applied", assign_o[3:2] === 2'b00, 64'(assign_o[3:2]), 64'd0);
        repeat (4) @(negedge clk);
        check("R8 frozen after conflict", assign_o === pack_model(), 64'(assign_o), 64'(pack_model()));

        // Falsified clause: A=0 with clause (A)
        load_clause(0, lit(0, 0));
        load_clause(1, filler);
        a = '{2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00};
        set_all(a);
        do_run("R6 falsified", 1'b0);
        check("R6 conflict", conflict === 1'b1, 64'(conflict), 64'd1);

        // Satisfied clause (A + B) with A=1; unknown code 11 stored as free
        load_clause(0, lit(0, 0) | lit(1, 0));
        a = '{2'b10, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00};
        set_all(a);
        check("R9 code 11 stored free", assign_o[3:2] === 2'b00, 64'(assign_o[3:2]), 64'd0);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R8 new start clears conflict", conflict === 1'b0 && busy === 1'b1,
              {62'd0, conflict, busy}, 64'h1);
        start = 1'b0;
        while (done !== 1'b1) begin @(posedge clk); @(negedge clk); end
        check("R10 satisfied clause no force", assign_o[3:2] === 2'b00 && conflict === 1'b0,
              {61'd0, conflict, assign_o[3:2]}, 64'd0);

        // Writes and mask shifts during a run are ignored
        load_clause(0, lit(0, 1) | lit(1, 1));
        a = '{2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00};
        set_all(a);
        do_run("R2 R9 ignored while busy", 1'b1);
        check("R9 var0 not written in run", assign_o[1:0] === 2'b01, 64'(assign_o[1:0]), 64'd1);
        a = '{2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00};
        set_all(a);
        do_run("R2 mask unchanged", 1'b0);

        // Random formulas and partial assignments
        for (int t = 0; t < 60; t++) begin
            logic [MW-1:0] mk;
            for (int c = 0; c < NC; c++) begin
                mk = '0;
                for (int l = 0; l < MW; l++) if ($urandom % 6 == 0) mk[l] = 1'b1;
                if (mk == '0) mk = lit($urandom % NV, $urandom % 2);
                load_clause(c, mk);
            end
            for (int v = 0; v < NV; v++) a[v] = ($urandom % 3 == 0) ? 2'(($urandom % 3)) : 2'b00;
            set_all(a);
            do_run("R11 random", 1'b0);
        end

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule